// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage register with a serial output. Each stage can be filled from a parallel input word, or the whole chain can move one position with a new bit entering at the first stage. Only the last stage can be seen from outside. The block runs entirely on a fast system clock. The slow shift clock and the inhibit input are sampled as ordinary signals and combined by OR. A rising edge of the combined level is an advance event, and each advance event moves the register one step. Either pin can serve as the clock while the other gates it. An active-low asynchronous clear empties the register at once and overrides every other input.

Both slow pins pass through a two-flop synchronizer. A three-state machine then follows the combined level. `ST_CLEAR` is held while clear is asserted. `ST_ARMED` means the combined level is low. `ST_BLOCKED` means it is high. The transitions are:

- `ST_ARMED` goes to `ST_BLOCKED` when the combined level goes high. This is the only transition that issues an advance.
- `ST_BLOCKED` goes to `ST_ARMED` when the level falls.
- `ST_CLEAR` goes to `ST_ARMED` or `ST_BLOCKED`, matching the current level, on the first system clock after clear is released. This exit issues no advance.

The mode, serial and parallel inputs are sampled in the system clock cycle in which the advance is issued.

Top module: `gated_piso_shifter`

## Requirements
- R1: The register has eight stages, A (index 0) to H (index 7). `ser_out` is stage H, taken directly from its flop.
- R2: With `mode_shift`=1, an advance event loads `ser_in` into stage A and moves each stage i into stage i+1.
- R3: With `mode_shift`=0, an advance event loads `par_in[i]` into stage i, so `par_in[0]` goes to A and `par_in[7]` goes to H. `ser_in` has no effect.
- R4: The load is synchronous. Holding `mode_shift` low with new `par_in` values and no advance event leaves every stage unchanged.
- R5: An advance event is a low-to-high change of (`shift_clk` OR `shift_inh`) as seen after the synchronizer. The stages show the result within four system clock cycles of the pin change.
- R6: While `shift_inh` is high, toggling `shift_clk` causes no advance.
- R7: Raising `shift_inh` while `shift_clk` is low causes one advance. Raising it while `shift_clk` is high causes none.
- R8: While `clr_n` is low, every stage reads zero immediately, regardless of the clock, inhibit, mode and data inputs.
- R9: Releasing `clr_n` causes no advance, even when the combined clock level is already high.
- R10: Without an advance event, all stages hold. A combined level held high gives exactly one advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_clk | input | 1 | Slow shift clock pin, sampled |
| shift_inh | input | 1 | Clock inhibit pin, sampled; combined with shift_clk by OR |
| mode_shift | input | 1 | 1 = serial shift, 0 = parallel load |
| ser_in | input | 1 | Serial data entering stage A |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i |
| ser_out | output | 1 | Last stage (H) |

## Verification
The bench loads all 256 parallel words. It then shifts each word out while shifting in a different pattern. A bit-order mistake, a wrong load lane, or a shift that repeats while the clock level stays high would each corrupt the serial stream.

Targeted sequences cover five corner cases, each aimed at a specific fault:

- Inhibit edges with the clock low and with the clock high. A design that detects edges on the clock pin alone would miss the first; one that ignores the gate would act on the second.
- Clock toggles while inhibited. A design that ignores the gate would shift here.
- A mode change with no edge. An asynchronous load would change the stages here.
- Clear applied while edges keep arriving.
- Clear released with the clock level already high. A history register reset to low would load a spurious word here.

// File: rtl/gated_piso_pkg.sv
package gated_piso_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR   = 2'd0,
        ST_ARMED   = 2'd1,
        ST_BLOCKED = 2'd2
    } adv_state_t;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } op_mode_t;

endpackage

// File: rtl/gated_piso_sync.sv
module gated_piso_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        chain[0] <= din;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign dout = chain[LAST];
endmodule

// File: rtl/gated_piso_adv_fsm.sv
module gated_piso_adv_fsm
    import gated_piso_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic       gate_hi,
    output logic       advance,
    output adv_state_t state_q
);
    adv_state_t state_d;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:   state_d = gate_hi ? ST_BLOCKED : ST_ARMED;
            ST_ARMED:   state_d = gate_hi ? ST_BLOCKED : ST_ARMED;
            ST_BLOCKED: state_d = gate_hi ? ST_BLOCKED : ST_ARMED;
            default:    state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        advance = 1'b0;
        unique case (state_q)
            ST_ARMED:   advance = gate_hi;
            ST_CLEAR,
            ST_BLOCKED: advance = 1'b0;
            default:    advance = 1'b0;
        endcase
    end
endmodule

// File: rtl/gated_piso_stages.sv
module gated_piso_stages
    import gated_piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             advance,
    input  op_mode_t         mode,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stage_q
);
    logic [WIDTH-1:0] stage_d;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_lane
            logic from_left;
            if (i == 0) begin : g_head
                assign from_left = ser_in;
            end else begin : g_body
                assign from_left = stage_q[i-1];
            end
            always_comb begin
                if (!advance)                stage_d[i] = stage_q[i];
                else if (mode == MODE_SHIFT) stage_d[i] = from_left;
                else                         stage_d[i] = par_in[i];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/gated_piso_shifter.sv
module gated_piso_shifter
    import gated_piso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             shift_clk,
    input  logic             shift_inh,
    input  logic             mode_shift,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);
    localparam int TOP = WIDTH - 1;

    logic [1:0]       pins_s;
    logic             gate_hi;
    logic             advance;
    adv_state_t       state_q;
    logic [WIDTH-1:0] stage_q;
    op_mode_t         mode;

    gated_piso_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .din  ({shift_inh, shift_clk}),
        .dout (pins_s)
    );

    assign gate_hi = pins_s[0] | pins_s[1];

    gated_piso_adv_fsm fsm_i (
        .clk     (clk),
        .clr_n   (clr_n),
        .gate_hi (gate_hi),
        .advance (advance),
        .state_q (state_q)
    );

    assign mode = mode_shift ? MODE_SHIFT : MODE_LOAD;

    gated_piso_stages #(.WIDTH(WIDTH)) stages_i (
        .clk     (clk),
        .clr_n   (clr_n),
        .advance (advance),
        .mode    (mode),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .stage_q (stage_q)
    );

    assign ser_out = stage_q[TOP];
endmodule

// File: rtl/gated_piso_shifter_chk.sv
module gated_piso_shifter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             mode_shift,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic             advance,
    input logic [WIDTH-1:0] stage_q
);
    assert_clear_zero_R8: assert property (@(posedge clk)
        !clr_n |-> (stage_q == '0));

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (advance && mode_shift) |=>
            (stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}));

    assert_load_word_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (advance && !mode_shift) |=> (stage_q == $past(par_in)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!clr_n)
        !advance |=> $stable(stage_q));

    assert_single_event_R5: assert property (@(posedge clk) disable iff (!clr_n)
        advance |=> !advance);

    assert_release_quiet_R9: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> !advance);
endmodule

bind gated_piso_shifter gated_piso_shifter_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .clr_n      (clr_n),
    .mode_shift (mode_shift),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .advance    (advance),
    .stage_q    (stage_q)
);

// File: tb/gated_piso_shifter_tb_top.sv
module gated_piso_shifter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       shift_clk = 1'b0;
    logic       shift_inh = 1'b0;
    logic       mode_shift = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       ser_out;

    int total = 0;
    int bad = 0;
    logic [7:0] model = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_piso_shifter #(.WIDTH(8), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .clr_n      (clr_n),
        .shift_clk  (shift_clk),
        .shift_inh  (shift_inh),
        .mode_shift (mode_shift),
        .ser_in     (ser_in),
        .par_in     (par_in),
        .ser_out    (ser_out)
    );

    task automatic chk(input string tag, input logic exp);
        total++;
        if (ser_out !== exp) begin
            bad++;
            $display("FAIL %s: ser_out=%0b expected=%0b", tag, ser_out, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive pins, wait long enough for the synchronizer and FSM, update model
    task automatic step(input logic m, input logic s, input logic [7:0] p,
                        input logic ck, input logic ih, input logic adv);
        mode_shift = m;
        ser_in     = s;
        par_in     = p;
        shift_clk  = ck;
        shift_inh  = ih;
        waitn(4);
        if (adv) model = m ? {model[6:0], s} : p;
    endtask

    task automatic pulse(input logic m, input logic s, input logic [7:0] p);
        step(m, s, p, 1'b1, 1'b0, 1'b1);
        step(m, s, p, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 8; k++) begin
            chk(tag, model[7]);
            pulse(1'b1, 1'b0, 8'h00);
        end
        chk(tag, model[7]);
    endtask

    initial begin
        #(WATCHDOG * CLK_PERIOD);
        bad++;
        $display("FAIL watchdog R5: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1 clr_n = 1'b0;
        waitn(3);
        chk("R8 reset state", 1'b0);
        clr_n = 1'b1;
        waitn(4);
        chk("R9 quiet after release", 1'b0);

        // R1 R2 R3: all parallel words, shifted out against a new pattern
        for (int v = 0; v < 256; v++) begin
            logic [7:0] w;
            logic [7:0] fill;
            w    = 8'(v);
            fill = w ^ 8'hA5;
            pulse(1'b0, ~w[7], w);
            chk("R3 load lane H", w[7]);
            for (int k = 0; k < 8; k++) begin
                pulse(1'b1, fill[k], ~w);
                chk("R2 shift order R1", model[7]);
            end
        end

        // R4: load mode with new word but no edge
        pulse(1'b0, 1'b0, 8'h81);
        chk("R4 setup", 1'b1);
        mode_shift = 1'b0;
        par_in     = 8'h7E;
        waitn(12);
        chk("R4 no async load", 1'b1);
        drain("R4 contents kept");

        // R6: clock toggles while inhibited
        pulse(1'b0, 1'b0, 8'hC3);
        step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1); // inh rise with clk low
        for (int k = 0; k < 5; k++) begin
            step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
            step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
        end
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        drain("R6 inhibit blocks clock");

        // R7: inhibit as clock, with and without clk high
        pulse(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) pulse(1'b1, 1'b0, 8'h00);
        chk("R7 inh rise clk low advances", model[7]);
        drain("R7 inh rise clk high ignored");

        // R10: held-high level advances once
        pulse(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1);
        waitn(20);
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        drain("R10 single advance");

        // R8: clear overrides edges and data
        pulse(1'b0, 1'b0, 8'hFF);
        chk("R8 setup", 1'b1);
        clr_n = 1'b0;
        #1;
        chk("R8 immediate clear", 1'b0);
        model = 8'h00;
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0);
        chk("R8 clear overrides load", 1'b0);

        // R9: release with combined level high, load word pending
        clr_n = 1'b1;
        waitn(8);
        chk("R9 no spurious load", 1'b0);
        step(1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 8'hFF);
        chk("R9 normal after release R5", 1'b1);
        drain("R9 drain");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule